// File: doc/BRIEF.md
# Branch target buffer predictor

This block predicts, during the fetch cycle, whether a conditional branch at the current fetch address will be taken and where fetch should go next. It keeps a direct-mapped table of entries, each holding a valid flag, an address tag, a branch target and a four-state saturating direction machine. A lookup that finds a valid entry with a matching tag uses the stored state and target. A lookup that misses uses a static rule: a branch with a backward (negative) displacement is predicted taken, and anything else falls through.

Resolved branches come back on an update port carrying the branch address, its outcome and its target. An update either trains the entry that already holds that branch or claims the entry for it, replacing whatever occupied that slot. The lookup is combinational on the fetch address and the decoded displacement. Updates are written on the clock edge, so they are seen by lookups from the following cycle onward.

Top module: `btbPredictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update has been accepted.
- R2: The entry is selected by fetch address bits [10:2] and the tag is bits [31:11]. A lookup hits only when the selected entry is valid and its tag equals those bits, so two addresses sharing an index but differing in tag never hit each other's entry.
- R3: On a miss the branch is predicted taken exactly when bit 31 of the displacement is set, with a next address of fetch address plus displacement. A zero displacement counts as not taken.
- R4: Whenever the prediction is not taken, the predicted next address is the fetch address plus 4.
- R5: On a hit predicted taken, the predicted next address is the target stored in the entry.
- R6: The direction state is a 4-bit one-hot field: 0001 strongly not taken, 0010 weakly not taken, 0100 weakly taken, 1000 strongly taken. A hit predicts taken in the two taken-leaning states (0100, 1000) and not taken otherwise.
- R7: An update for a branch already held moves its state one step toward strongly taken on a taken outcome and one step toward strongly not taken otherwise. It saturates at both ends without wrapping.
- R8: An update for a branch not held writes its tag and target and sets the state to weakly taken if taken, or weakly not taken otherwise, replacing any entry at that index.
- R9: A taken update of a held branch replaces the stored target with the resolved target. A not-taken update leaves the target unchanged.
- R10: A lookup in the same cycle as an update to the same entry sees the entry as it was before that update. The update becomes visible from the next cycle.
- R11: While the update valid input is low, no entry changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | 32 | Address being fetched |
| fetchDisp | input | 32 | Decoded branch displacement, two's complement |
| updValid | input | 1 | An update is presented this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 for taken |
| updTarget | input | 32 | Resolved branch target |
| predTaken | output | 1 | Predicted direction |
| predTarget | output | 32 | Predicted next fetch address |
| predHit | output | 1 | Lookup found a valid entry with a matching tag |

## Verification
The checker evaluates on every cycle the properties that need no knowledge of table contents. These are the static miss rule, the fall-through address on every not-taken prediction, the one-hot shape of a hit entry's state, the absence of hits before any update since reset, and the hit that must follow an update when the same address is looked up on the next cycle. The training sequence itself can only be shown by the bench's scenarios, comparing each cycle against a behavioural model of the table. This covers saturation at both ends, the weak starting states, the target refresh, tag aliasing between addresses sharing an index, and same-cycle read-before-write ordering.

// File: rtl/btbPkg.sv
`timescale 1ns/1ps
package btbPkg;

  // Width of the one-hot direction field held in every entry
  localparam int STATE_W = 4;

  localparam logic [STATE_W-1:0] ST_STRONG_NT = 4'b0001;
  localparam logic [STATE_W-1:0] ST_WEAK_NT   = 4'b0010;
  localparam logic [STATE_W-1:0] ST_WEAK_T    = 4'b0100;
  localparam logic [STATE_W-1:0] ST_STRONG_T  = 4'b1000;

  // Strobes from control to datapath
  typedef struct packed {
    logic                wrAlloc;    // claim entry: tag, target, state, valid
    logic                wrState;    // train state of a held entry
    logic                wrTarget;   // refresh target of a held entry
    logic [STATE_W-1:0]  nextState;  // state to be written
    logic                selTable;   // next address from stored target
    logic                selDisp;    // next address from pc + displacement
  } btbStrobes_t;

endpackage

// File: rtl/btbDatapath.sv
`timescale 1ns/1ps
module btbDatapath
  import btbPkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int PC_W    = 32,
  parameter int ALIGN   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PC_W-1:0]    fetchPc,
  input  logic [PC_W-1:0]    fetchDisp,
  input  logic               updValid,
  input  logic [PC_W-1:0]    updPc,
  input  logic [PC_W-1:0]    updTarget,
  input  btbStrobes_t        stb,
  output logic               lookHit,
  output logic [STATE_W-1:0] lookState,
  output logic               updHit,
  output logic [STATE_W-1:0] updState,
  output logic [PC_W-1:0]    predTarget
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - ALIGN;
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;

  logic [IDX_W-1:0] lookIdx, updIdx;
  logic [TAG_W-1:0] lookTag, updTag;

  assign lookIdx = fetchPc[ALIGN +: IDX_W];
  assign lookTag = fetchPc[PC_W-1 -: TAG_W];
  assign updIdx  = updPc[ALIGN +: IDX_W];
  assign updTag  = updPc[PC_W-1 -: TAG_W];

  // Flattened views of the per-entry registers
  logic [ENTRIES-1:0]         validVec;
  logic [ENTRIES*TAG_W-1:0]   tagFlat;
  logic [ENTRIES*PC_W-1:0]    targetFlat;
  logic [ENTRIES*STATE_W-1:0] stateFlat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic               validQ;
    logic [TAG_W-1:0]   tagQ;
    logic [PC_W-1:0]    targetQ;
    logic [STATE_W-1:0] stateQ;
    logic               sel;

    assign sel = updValid && (updIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
      end else if (sel && stb.wrAlloc) begin
        validQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        if (stb.wrAlloc) begin
          tagQ    <= updTag;
          targetQ <= updTarget;
          stateQ  <= stb.nextState;
        end else begin
          if (stb.wrState)  stateQ  <= stb.nextState;
          if (stb.wrTarget) targetQ <= updTarget;
        end
      end
    end

    assign validVec[e]                       = validQ;
    assign tagFlat[e*TAG_W +: TAG_W]         = tagQ;
    assign targetFlat[e*PC_W +: PC_W]        = targetQ;
    assign stateFlat[e*STATE_W +: STATE_W]   = stateQ;
  end

  // Lookup read port
  logic [TAG_W-1:0] lookTagRd;
  logic [PC_W-1:0]  lookTargetRd;

  assign lookTagRd    = tagFlat[lookIdx*TAG_W +: TAG_W];
  assign lookTargetRd = targetFlat[lookIdx*PC_W +: PC_W];
  assign lookState    = stateFlat[lookIdx*STATE_W +: STATE_W];
  assign lookHit      = validVec[lookIdx] && (lookTagRd == lookTag);

  // Update read port
  logic [TAG_W-1:0] updTagRd;

  assign updTagRd = tagFlat[updIdx*TAG_W +: TAG_W];
  assign updState = stateFlat[updIdx*STATE_W +: STATE_W];
  assign updHit   = validVec[updIdx] && (updTagRd == updTag);

  // Next fetch address
  logic [PC_W-1:0] dispAddr, seqAddr;

  assign dispAddr = fetchPc + fetchDisp;
  assign seqAddr  = fetchPc + STEP;

  always_comb begin
    if (stb.selTable)     predTarget = lookTargetRd;
    else if (stb.selDisp) predTarget = dispAddr;
    else                  predTarget = seqAddr;
  end

endmodule

// File: rtl/btbControl.sv
`timescale 1ns/1ps
module btbControl
  import btbPkg::*;
(
  input  logic               updValid,
  input  logic               updTaken,
  input  logic               updHit,
  input  logic [STATE_W-1:0] updState,
  input  logic               lookHit,
  input  logic [STATE_W-1:0] lookState,
  input  logic               dispNeg,
  output btbStrobes_t        stb,
  output logic               predTaken
);

  localparam int HALF = STATE_W / 2;

  // One step toward strongly taken, held at the top
  function automatic logic [STATE_W-1:0] stepUp(input logic [STATE_W-1:0] s);
    return s[STATE_W-1] ? s : (s << 1);
  endfunction

  // One step toward strongly not taken, held at the bottom
  function automatic logic [STATE_W-1:0] stepDown(input logic [STATE_W-1:0] s);
    return s[0] ? s : (s >> 1);
  endfunction

  logic tableTaken;
  assign tableTaken = |lookState[STATE_W-1:HALF];

  always_comb begin
    predTaken = lookHit ? tableTaken : dispNeg;

    stb           = '0;
    stb.selTable  = lookHit && tableTaken;
    stb.selDisp   = !lookHit && dispNeg;

    if (updValid) begin
      if (updHit) begin
        stb.wrState   = 1'b1;
        stb.wrTarget  = updTaken;
        stb.nextState = updTaken ? stepUp(updState) : stepDown(updState);
      end else begin
        stb.wrAlloc   = 1'b1;
        stb.nextState = updTaken ? ST_WEAK_T : ST_WEAK_NT;
      end
    end
  end

endmodule

// File: rtl/btbPredictor.sv
`timescale 1ns/1ps
module btbPredictor
  import btbPkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int PC_W    = 32,
  parameter int ALIGN   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] fetchDisp,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  output logic            predTaken,
  output logic [PC_W-1:0] predTarget,
  output logic            predHit
);

  btbStrobes_t        stb;
  logic               lookHit, updHit;
  logic [STATE_W-1:0] lookState, updState;

  btbDatapath #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ALIGN(ALIGN)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .fetchDisp  (fetchDisp),
    .updValid   (updValid),
    .updPc      (updPc),
    .updTarget  (updTarget),
    .stb        (stb),
    .lookHit    (lookHit),
    .lookState  (lookState),
    .updHit     (updHit),
    .updState   (updState),
    .predTarget (predTarget)
  );

  btbControl u_control (
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updHit    (updHit),
    .updState  (updState),
    .lookHit   (lookHit),
    .lookState (lookState),
    .dispNeg   (fetchDisp[PC_W-1]),
    .stb       (stb),
    .predTaken (predTaken)
  );

  assign predHit = lookHit;

endmodule

// File: rtl/btbChecker.sv
`timescale 1ns/1ps
module btbChecker
  import btbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [PC_W-1:0]    fetchPc,
  input logic [PC_W-1:0]    fetchDisp,
  input logic               updValid,
  input logic [PC_W-1:0]    updPc,
  input logic               predTaken,
  input logic [PC_W-1:0]    predTarget,
  input logic               predHit,
  input logic [STATE_W-1:0] lookState
);

  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;

  logic seenUpd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenUpd <= 1'b0;
    else if (updValid) seenUpd <= 1'b1;
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !seenUpd |-> !predHit); // R1

  AST_MISS_BY_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (predTaken == fetchDisp[PC_W-1])); // R3

  AST_MISS_TAKEN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!predHit && predTaken) |-> (predTarget == fetchPc + fetchDisp)); // R3

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> (predTarget == fetchPc + STEP)); // R4

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    predHit |-> $onehot(lookState)); // R6

  AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> ((fetchPc != $past(updPc)) || predHit)); // R8

endmodule

bind btbPredictor btbChecker #(.PC_W(PC_W), .ALIGN(ALIGN)) u_btbChecker (
  .clk        (clk),
  .rstN       (rstN),
  .fetchPc    (fetchPc),
  .fetchDisp  (fetchDisp),
  .updValid   (updValid),
  .updPc      (updPc),
  .predTaken  (predTaken),
  .predTarget (predTarget),
  .predHit    (predHit),
  .lookState  (lookState)
);

// File: tb/test_btbPredictor.sv
`timescale 1ns/1ps
module test_btbPredictor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0, fetchDisp = '0, updPc = '0, updTarget = '0;
  logic        updValid = 1'b0, updTaken = 1'b0;
  logic        predTaken, predHit;
  logic [31:0] predTarget;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model: entry index -> contents, state as 0..3
  logic [31:0] mTag [int];
  logic [31:0] mTgt [int];
  int          mSt  [int];

  always #5 clk = ~clk;

  btbPredictor i_btbPredictor (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchDisp(fetchDisp),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .predTaken(predTaken), .predTarget(predTarget), .predHit(predHit)
  );

  function automatic int idxOf(input logic [31:0] pc);
    return int'((pc >> 2) & 32'h1FF);
  endfunction

  task automatic step(input logic [31:0] fpc, input logic [31:0] fdisp,
                      input logic uv, input logic [31:0] upc, input logic ut,
                      input logic [31:0] utgt, input string req);
    int          li, ui;
    logic        hitE, takE;
    logic [31:0] tgtE;
    @(negedge clk);
    fetchPc = fpc; fetchDisp = fdisp;
    updValid = uv; updPc = upc; updTaken = ut; updTarget = utgt;
    #1;
    li   = idxOf(fpc);
    hitE = mTag.exists(li) && (mTag[li] == (fpc >> 11));
    takE = hitE ? (mSt[li] >= 2) : fdisp[31];
    tgtE = takE ? (hitE ? mTgt[li] : fpc + fdisp) : fpc + 32'd4;
    checks++;
    if (predHit !== hitE || predTaken !== takE || predTarget !== tgtE) begin
      fails++;
      $display("FAIL %s pc=%h: hit/taken/target actual %b/%b/%h expected %b/%b/%h",
               req, fpc, predHit, predTaken, predTarget, hitE, takE, tgtE);
    end
    @(posedge clk);
    if (uv) begin
      ui = idxOf(upc);
      if (mTag.exists(ui) && mTag[ui] == (upc >> 11)) begin
        mSt[ui] = ut ? ((mSt[ui] < 3) ? mSt[ui] + 1 : 3) : ((mSt[ui] > 0) ? mSt[ui] - 1 : 0);
        if (ut) mTgt[ui] = utgt;
      end else begin
        mTag[ui] = upc >> 11;
        mTgt[ui] = utgt;
        mSt[ui]  = ut ? 2 : 1;
      end
    end
  endtask

  task automatic look(input logic [31:0] fpc, input logic [31:0] fdisp, input string req);
    step(fpc, fdisp, 1'b0, 32'hDEAD_BEE0, 1'b1, 32'h0BAD_0000, req);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  localparam logic [31:0] LOOP_PC = 32'h0000_1040;
  localparam logic [31:0] ALT_PC  = 32'h0000_2088;
  localparam logic [31:0] SAT_PC  = 32'h0000_3010;
  localparam logic [31:0] REF_PC  = 32'h0000_4444;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty table after reset
    look(32'h0000_0100, 32'hFFFF_FFF0, "R1");
    look(LOOP_PC, 32'h0000_0040, "R1");
    // R3 / R4: static rule on misses
    look(32'h0000_0300, 32'hFFFF_FF00, "R3");
    look(32'h0000_0300, 32'h0000_0000, "R3");
    look(32'h0000_0304, 32'h0000_0040, "R4");

    // Looping branch: six taken then one exit, lookup and update together (R10)
    for (int it = 0; it < 4; it++) begin
      for (int k = 0; k < 7; k++) begin
        step(LOOP_PC, 32'h0000_0040, 1'b1, LOOP_PC, (k != 6), 32'h0000_1000,
             (k == 0) ? "R10" : "R7");
        look(LOOP_PC, 32'h0000_0040, "R5");
      end
    end

    // Alternating branch (R6 taken-leaning states)
    for (int k = 0; k < 12; k++) begin
      step(ALT_PC, 32'hFFFF_FF80, 1'b1, ALT_PC, k[0], 32'h0000_2000, "R6");
      look(ALT_PC, 32'hFFFF_FF80, "R6");
    end

    // Saturation at the not-taken end, then recovery (R7)
    for (int k = 0; k < 6; k++)
      step(SAT_PC, 32'hFFFF_FFF0, 1'b1, SAT_PC, 1'b0, 32'h0000_3000, "R7");
    look(SAT_PC, 32'hFFFF_FFF0, "R7");
    step(SAT_PC, 32'hFFFF_FFF0, 1'b1, SAT_PC, 1'b1, 32'h0000_3000, "R7");
    look(SAT_PC, 32'hFFFF_FFF0, "R7");
    step(SAT_PC, 32'hFFFF_FFF0, 1'b1, SAT_PC, 1'b1, 32'h0000_3000, "R7");
    look(SAT_PC, 32'hFFFF_FFF0, "R7");

    // Aliasing on the loop branch's index (R2, R8)
    look(LOOP_PC + 32'h800, 32'hFFFF_FFF0, "R2");
    step(32'h0000_0500, 32'h0000_0010, 1'b1, LOOP_PC + 32'h800, 1'b0, 32'h0000_5000, "R8");
    look(LOOP_PC + 32'h800, 32'hFFFF_FFF0, "R8");
    look(LOOP_PC, 32'h0000_0040, "R2");

    // Target refresh on taken, kept on not taken (R9)
    step(32'h0000_0600, 32'h0, 1'b1, REF_PC, 1'b1, 32'h0000_4000, "R8");
    look(REF_PC, 32'h0000_0040, "R5");
    step(32'h0000_0600, 32'h0, 1'b1, REF_PC, 1'b1, 32'h0000_4100, "R9");
    look(REF_PC, 32'h0000_0040, "R9");
    step(32'h0000_0600, 32'h0, 1'b1, REF_PC, 1'b0, 32'h0000_7700, "R9");
    look(REF_PC, 32'h0000_0040, "R9");

    // Update inputs ignored while not valid (R11)
    for (int k = 0; k < 4; k++)
      step(32'h0000_0700, 32'h0, 1'b0, REF_PC, 1'b0, 32'h0000_9900, "R11");
    look(REF_PC, 32'h0000_0040, "R11");
    look(32'h0000_0700, 32'h0000_0020, "R11");

    done = 1'b1;
    finishRun();
  end

endmodule